// File: doc/BRIEF.md
# Power-Up Sequencer with Fault Recovery Policy

This block brings a powered device's input rail up in a fixed order and decides how to recover when something goes wrong. Once the handshake front end reports that detection and classification are done and the undervoltage release flag has been seen, it enables the inrush path. When the bulk rail reports good, it hands over to the isolated converter. Power-good is raised only after the converter enable has held for a qualification time. All analog decisions arrive as already-resolved digital flags.

On a fault the block records the first fault and the state in which it happened, then applies a policy chosen by the fault class. Hard faults latch off until an external clear. Transient faults use a short fixed hiccup. All other faults use a backoff delay that doubles on each retry and resets once the run state has proved stable. Restart attempts are budgeted within a time window, and running out of the budget locks the block out. A late bulk rail is treated as a fault by an inrush timer. Together these rules stop a restart storm from forming.

Top module: `pwrseq_ctrl`

## Requirements
- R1: After reset the state code is 0 (idle), both enables and power-good are low, the retry count is 0, the action code is 0 (none), lockout is low and the first-fault code is 0.
- R2: State codes are idle=0, inrush=1, run=2, fault=3, retry=4. Idle moves to inrush when `det_done` is high, undervoltage is released and no fault flag is set. Inrush moves to run when `bulk_ok` is high. `inrush_en` is high only in inrush and `conv_en` is high only in run.
- R3: If `bulk_ok` is still low after INRUSH_TO cycles in inrush, the block enters fault with fault code 6. The inrush state lasts exactly INRUSH_TO cycles in that case.
- R4: Undervoltage uses two flags. `uvlo_trip` forces a fault (code 1) from inrush or run. Removing `uvlo_clear` alone has no effect in run. After a trip, neither idle nor retry moves on to inrush until `uvlo_clear` has been seen; the release takes effect two clock edges after `uvlo_clear` rises.
- R5: Fault codes follow a fixed priority: short=5, then overtemperature=4, then overcurrent=3, then overvoltage=2, then undervoltage=1.
- R6: When a fault is entered, `first_code` and `first_state` capture the code and the previous state in that same cycle, while `action` still holds its old value. The new action appears one cycle later. Later faults do not overwrite the first-fault record until a clear.
- R7: `fault_cls` is sampled when a fault is entered. Values 2 and 3 latch the block in fault with action 1 (latch) until `clear_latch` is pulsed; the pulse returns the block to idle and clears the first-fault record, the action, lockout and the retry count. `clear_latch` has no effect in any other situation.
- R8: `fault_cls` 1 selects hiccup (action 2): retry lasts BACKOFF_BASE cycles every time and does not escalate.
- R9: `fault_cls` 0 and the inrush timeout select backoff (action 3): the retry state lasts the current delay. The delay starts at BACKOFF_BASE and doubles after each backoff retry, up to BACKOFF_MAX.
- R10: The backoff delay returns to BACKOFF_BASE once run has been held for STABLE_T consecutive cycles.
- R11: Each hiccup or backoff retry increments `retry_cnt`. A fault that arrives while the count equals RETRY_CAP locks out instead (`lockout` high, action 1, state held in fault). The count returns to 0 WINDOW cycles after the first retry of a window.
- R12: `pg` rises after PG_QUAL cycles of continuous run and falls in the same cycle that the state code becomes fault.
- R13: `evt` is high for exactly one cycle, in the first cycle of each new state, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| det_done | input | 1 | Detection and classification complete |
| uvlo_trip | input | 1 | Input undervoltage asserted (lower threshold) |
| uvlo_clear | input | 1 | Input undervoltage released (upper threshold) |
| bulk_ok | input | 1 | Bulk rail reached its good level |
| ovp | input | 1 | Overvoltage flag |
| ocp | input | 1 | Overcurrent flag |
| otp | input | 1 | Overtemperature flag |
| short_det | input | 1 | Output short flag |
| fault_cls | input | 2 | Fault class: 0 backoff, 1 hiccup, 2/3 hard latch |
| clear_latch | input | 1 | External clear of a latched fault or lockout |
| inrush_en | output | 1 | Inrush path enable |
| conv_en | output | 1 | Converter enable |
| pg | output | 1 | Qualified power-good |
| state_code | output | 3 | Current state code |
| evt | output | 1 | One-cycle state-change strobe |
| retry_cnt | output | CNT_W | Retries in the current window |
| action | output | 2 | Last recovery action: 0 none, 1 latch, 2 hiccup, 3 backoff |
| lockout | output | 1 | Retry budget exhausted |
| first_code | output | 3 | First fault code since the last clear |
| first_state | output | 3 | State code at first-fault entry |

## Verification
A wrong internal state shows up quickly at the ports. A corrupted state register changes `state_code` and the enables in the very next cycle. A timer or delay register that is off by one changes the measured dwell in inrush or retry by exactly that amount, so dwell times are counted in whole cycles against the expected timeout and doubling sequence. Budget and window errors show up as a lockout arriving one retry early or late, or as `retry_cnt` failing to return to zero after the window. A wrong first-fault capture becomes visible in the fault-entry cycle, and on a later fault, as a `first_code` that differs from the fault that was injected first.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_INRUSH = 3'd1,
      ST_RUN    = 3'd2,
      ST_FAULT  = 3'd3,
      ST_RETRY  = 3'd4
   } seq_state_e;

   typedef enum logic [1:0] {
      ACT_NONE    = 2'd0,
      ACT_LATCH   = 2'd1,
      ACT_HICCUP  = 2'd2,
      ACT_BACKOFF = 2'd3
   } rec_act_e;

   localparam logic [2:0] FC_NONE    = 3'd0;
   localparam logic [2:0] FC_UVLO    = 3'd1;
   localparam logic [2:0] FC_OVP     = 3'd2;
   localparam logic [2:0] FC_OCP     = 3'd3;
   localparam logic [2:0] FC_OTP     = 3'd4;
   localparam logic [2:0] FC_SHORT   = 3'd5;
   localparam logic [2:0] FC_TIMEOUT = 3'd6;
endpackage

// File: rtl/pwrseq_fault_enc.sv
module pwrseq_fault_enc
   import pwrseq_pkg::*;
(
   input  logic       uvlo_trip,
   input  logic       ovp,
   input  logic       ocp,
   input  logic       otp,
   input  logic       short_det,
   output logic       hit,
   output logic [2:0] code
);
   // fixed severity order, most severe first
   always_comb begin
      if (short_det)      code = FC_SHORT;
      else if (otp)       code = FC_OTP;
      else if (ocp)       code = FC_OCP;
      else if (ovp)       code = FC_OVP;
      else if (uvlo_trip) code = FC_UVLO;
      else                code = FC_NONE;
   end
   assign hit = (code != FC_NONE);
endmodule

// File: rtl/pwrseq_backoff.sv
module pwrseq_backoff #(
   parameter  int BASE     = 4,
   parameter  int MAX      = 8,
   parameter  int ESCALATE = 1,
   localparam int DW       = $clog2(MAX + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restore,
   input  logic          take_backoff,
   input  logic          take_hiccup,
   output logic [DW-1:0] delay_q
);
   logic [DW-1:0] cur_q;
   logic [DW-1:0] cur_nx;

   generate
      if (ESCALATE != 0) begin : g_double
         always_comb begin
            if (cur_q > DW'(MAX / 2)) cur_nx = DW'(MAX);
            else                      cur_nx = cur_q << 1;
         end
      end else begin : g_fixed
         assign cur_nx = cur_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q   <= DW'(BASE);
         delay_q <= DW'(BASE);
      end else if (restore) begin
         cur_q   <= DW'(BASE);
      end else if (take_backoff) begin
         delay_q <= cur_q;
         cur_q   <= cur_nx;
      end else if (take_hiccup) begin
         delay_q <= DW'(BASE);
      end
   end
endmodule

// File: rtl/pwrseq_budget.sv
module pwrseq_budget #(
   parameter  int CAP    = 3,
   parameter  int WINDOW = 400,
   localparam int CW     = $clog2(CAP + 1),
   localparam int WW     = $clog2(WINDOW)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          attempt,
   output logic [CW-1:0] cnt,
   output logic          at_cap
);
   logic [WW-1:0] win_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         win_q <= '0;
      end else if (clr) begin
         cnt   <= '0;
         win_q <= '0;
      end else if (attempt) begin
         cnt <= cnt + CW'(1);
         if (cnt == '0) win_q <= '0;
         else           win_q <= win_q + WW'(1);
      end else if (cnt != '0) begin
         if (win_q == WW'(WINDOW - 1)) begin
            cnt   <= '0;
            win_q <= '0;
         end else begin
            win_q <= win_q + WW'(1);
         end
      end
   end

   assign at_cap = (cnt == CW'(CAP));
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
   import pwrseq_pkg::*;
#(
   parameter  int INRUSH_TO    = 20,
   parameter  int BACKOFF_BASE = 4,
   parameter  int BACKOFF_MAX  = 8,
   parameter  int STABLE_T     = 30,
   parameter  int PG_QUAL      = 8,
   parameter  int RETRY_CAP    = 3,
   parameter  int WINDOW       = 400,
   parameter  int ESCALATE     = 1,
   localparam int CNT_W        = $clog2(RETRY_CAP + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             det_done,
   input  logic             uvlo_trip,
   input  logic             uvlo_clear,
   input  logic             bulk_ok,
   input  logic             ovp,
   input  logic             ocp,
   input  logic             otp,
   input  logic             short_det,
   input  logic [1:0]       fault_cls,
   input  logic             clear_latch,
   output logic             inrush_en,
   output logic             conv_en,
   output logic             pg,
   output logic [2:0]       state_code,
   output logic             evt,
   output logic [CNT_W-1:0] retry_cnt,
   output logic [1:0]       action,
   output logic             lockout,
   output logic [2:0]       first_code,
   output logic [2:0]       first_state
);
   localparam int DW   = $clog2(BACKOFF_MAX + 1);
   localparam int TMAX = (INRUSH_TO > BACKOFF_MAX) ? INRUSH_TO : BACKOFF_MAX;
   localparam int TW   = $clog2(TMAX + 1);
   localparam int RSAT = (PG_QUAL > STABLE_T) ? PG_QUAL : STABLE_T;
   localparam int RW   = $clog2(RSAT + 1);

   generate
      if (INRUSH_TO < 2)                                       begin : g_chk_to   $error("INRUSH_TO must be at least 2"); end
      if (BACKOFF_BASE < 1 || BACKOFF_BASE > BACKOFF_MAX)      begin : g_chk_bo   $error("BACKOFF_BASE must lie in 1..BACKOFF_MAX"); end
      if (STABLE_T < 1 || PG_QUAL < 1)                         begin : g_chk_run  $error("run timers must be at least 1"); end
      if (RETRY_CAP < 1 || WINDOW < 2)                         begin : g_chk_bud  $error("retry budget parameters out of range"); end
   endgenerate

   seq_state_e    state, nxt;
   logic [TW-1:0] tmr;
   logic [RW-1:0] run_cnt;
   logic          uvlo_ok;
   logic          latched_q;
   logic [1:0]    cls_q;
   logic          flt_hit;
   logic [2:0]    flt_code;
   logic [2:0]    ent_code;
   logic          at_cap;
   logic [DW-1:0] delay_q;
   logic [TW-1:0] dly_m1;

   pwrseq_fault_enc u_enc (
      .uvlo_trip (uvlo_trip),
      .ovp       (ovp),
      .ocp       (ocp),
      .otp       (otp),
      .short_det (short_det),
      .hit       (flt_hit),
      .code      (flt_code)
   );

   // recovery decision, taken once per fault entry
   logic decide, go_latch, go_hiccup, go_backoff, do_clear, stable_hit;
   assign decide     = (state == ST_FAULT) && !latched_q;
   assign go_latch   = decide && (cls_q[1] || at_cap);
   assign go_hiccup  = decide && !go_latch && (cls_q == 2'b01);
   assign go_backoff = decide && !go_latch && (cls_q == 2'b00);
   assign do_clear   = (state == ST_FAULT) && latched_q && clear_latch;
   assign dly_m1     = TW'(delay_q) - TW'(1);

   always_comb begin
      nxt      = state;
      ent_code = flt_code;
      case (state)
         ST_IDLE:   if (det_done && uvlo_ok && !flt_hit) nxt = ST_INRUSH;
         ST_INRUSH: begin
            if (flt_hit)                         nxt = ST_FAULT;
            else if (bulk_ok)                    nxt = ST_RUN;
            else if (tmr == TW'(INRUSH_TO - 1)) begin
               nxt      = ST_FAULT;
               ent_code = FC_TIMEOUT;
            end
         end
         ST_RUN:    if (flt_hit) nxt = ST_FAULT;
         ST_FAULT: begin
            if (do_clear)                   nxt = ST_IDLE;
            else if (go_hiccup || go_backoff) nxt = ST_RETRY;
         end
         ST_RETRY:  if (tmr >= dly_m1 && uvlo_ok) nxt = ST_INRUSH;
         default:   nxt = ST_IDLE;
      endcase
   end

   assign stable_hit = (state == ST_RUN) && (nxt == ST_RUN) && (run_cnt == RW'(STABLE_T - 1));

   pwrseq_backoff #(
      .BASE     (BACKOFF_BASE),
      .MAX      (BACKOFF_MAX),
      .ESCALATE (ESCALATE)
   ) u_backoff (
      .clk          (clk),
      .rst_n        (rst_n),
      .restore      (stable_hit || do_clear),
      .take_backoff (go_backoff),
      .take_hiccup  (go_hiccup),
      .delay_q      (delay_q)
   );

   pwrseq_budget #(
      .CAP    (RETRY_CAP),
      .WINDOW (WINDOW)
   ) u_budget (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (do_clear),
      .attempt (go_hiccup || go_backoff),
      .cnt     (retry_cnt),
      .at_cap  (at_cap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         evt         <= 1'b0;
         tmr         <= '0;
         run_cnt     <= '0;
         uvlo_ok     <= 1'b0;
         latched_q   <= 1'b0;
         cls_q       <= 2'b00;
         action      <= ACT_NONE;
         lockout     <= 1'b0;
         first_code  <= FC_NONE;
         first_state <= ST_IDLE;
      end else begin
         state <= nxt;
         evt   <= (nxt != state);

         if (nxt != state)                                            tmr <= '0;
         else if ((state == ST_INRUSH || state == ST_RETRY) && tmr != TW'(TMAX)) tmr <= tmr + TW'(1);

         if (state == ST_RUN && nxt == ST_RUN) begin
            if (run_cnt != RW'(RSAT)) run_cnt <= run_cnt + RW'(1);
         end else begin
            run_cnt <= '0;
         end

         if (uvlo_trip)       uvlo_ok <= 1'b0;
         else if (uvlo_clear) uvlo_ok <= 1'b1;

         // evidence first: capture at entry, before any action is applied
         if (nxt == ST_FAULT && state != ST_FAULT) begin
            cls_q <= (ent_code == FC_TIMEOUT) ? 2'b00 : fault_cls;
            if (first_code == FC_NONE) begin
               first_code  <= ent_code;
               first_state <= state;
            end
         end

         if (do_clear) begin
            latched_q   <= 1'b0;
            lockout     <= 1'b0;
            action      <= ACT_NONE;
            first_code  <= FC_NONE;
            first_state <= ST_IDLE;
         end else if (go_latch) begin
            latched_q <= 1'b1;
            action    <= ACT_LATCH;
            if (!cls_q[1]) lockout <= 1'b1;
         end else if (go_hiccup) begin
            action <= ACT_HICCUP;
         end else if (go_backoff) begin
            action <= ACT_BACKOFF;
         end
      end
   end

   assign state_code = state;
   assign inrush_en  = (state == ST_INRUSH);
   assign conv_en    = (state == ST_RUN);
   assign pg         = (state == ST_RUN) && (run_cnt >= RW'(PG_QUAL));
endmodule

// File: rtl/pwrseq_ctrl_chk.sv
module pwrseq_ctrl_chk #(
   parameter  int INRUSH_TO = 20,
   parameter  int PG_QUAL   = 8,
   parameter  int RETRY_CAP = 3,
   localparam int CNT_W     = $clog2(RETRY_CAP + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clear_latch,
   input logic             inrush_en,
   input logic             conv_en,
   input logic             pg,
   input logic [2:0]       state_code,
   input logic             evt,
   input logic [CNT_W-1:0] retry_cnt,
   input logic [1:0]       action,
   input logic             lockout,
   input logic [2:0]       first_code
);
   int run_len;
   int inr_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_len <= 0;
         inr_len <= 0;
      end else begin
         run_len <= (state_code == 3'd2) ? ((run_len < 1000000) ? run_len + 1 : run_len) : 0;
         inr_len <= (state_code == 3'd1) ? ((inr_len < 1000000) ? inr_len + 1 : inr_len) : 0;
      end
   end

   a_r2_enable_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(inrush_en && conv_en));

   a_r3_inrush_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 3'd1) |-> (inr_len < INRUSH_TO));

   a_r12_pg_qualified: assert property (@(posedge clk) disable iff (!rst_n)
      pg |-> (run_len >= PG_QUAL));

   a_r13_evt_on_change: assert property (@(posedge clk) disable iff (!rst_n)
      evt == (state_code != $past(state_code)));

   a_r11_cnt_cap: assert property (@(posedge clk) disable iff (!rst_n)
      int'(retry_cnt) <= RETRY_CAP);

   a_r11_lock_in_fault: assert property (@(posedge clk) disable iff (!rst_n)
      lockout |-> (state_code == 3'd3 && action == 2'd1));

   a_r7_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 3'd3 && action == 2'd1 && !clear_latch) |=> (state_code == 3'd3));

   a_r9_retry_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 3'd4) |=> (state_code == 3'd4 || state_code == 3'd1));

   a_r6_first_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (first_code != 3'd0 && !clear_latch) |=> $stable(first_code));
endmodule

bind pwrseq_ctrl pwrseq_ctrl_chk #(
   .INRUSH_TO (INRUSH_TO),
   .PG_QUAL   (PG_QUAL),
   .RETRY_CAP (RETRY_CAP)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .clear_latch (clear_latch),
   .inrush_en   (inrush_en),
   .conv_en     (conv_en),
   .pg          (pg),
   .state_code  (state_code),
   .evt         (evt),
   .retry_cnt   (retry_cnt),
   .action      (action),
   .lockout     (lockout),
   .first_code  (first_code)
);

// File: tb/pwrseq_ctrl_tb.sv
module pwrseq_ctrl_tb;
   localparam int INRUSH_TO = 20;
   localparam int BASE      = 4;
   localparam int PG_QUAL   = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic det_done = 0, uvlo_trip = 0, uvlo_clear = 1, bulk_ok = 0;
   logic ovp = 0, ocp = 0, otp = 0, short_det = 0, clear_latch = 0;
   logic [1:0] fault_cls = 2'd0;
   logic inrush_en, conv_en, pg, evt, lockout;
   logic [2:0] state_code, first_code, first_state;
   logic [1:0] retry_cnt;
   logic [1:0] action;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   pwrseq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .det_done(det_done), .uvlo_trip(uvlo_trip),
      .uvlo_clear(uvlo_clear), .bulk_ok(bulk_ok), .ovp(ovp), .ocp(ocp), .otp(otp),
      .short_det(short_det), .fault_cls(fault_cls), .clear_latch(clear_latch),
      .inrush_en(inrush_en), .conv_en(conv_en), .pg(pg), .state_code(state_code),
      .evt(evt), .retry_cnt(retry_cnt), .action(action), .lockout(lockout),
      .first_code(first_code), .first_state(first_state)
   );

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic ceq(input string req, input int act, input int exp);
      check(act == exp, req, act, exp);
   endtask

   task automatic dwell(input logic [2:0] code, output int n);
      n = 0;
      while (state_code == code && n < 2000) begin
         n++;
         tick();
      end
   endtask

   task automatic do_reset();
      rst_n = 0; det_done = 0; uvlo_trip = 0; uvlo_clear = 1; bulk_ok = 0;
      ovp = 0; ocp = 0; otp = 0; short_det = 0; clear_latch = 0; fault_cls = 0;
      repeat (3) tick();
      rst_n = 1;
      tick();
   endtask

   task automatic go_run();
      det_done = 1; bulk_ok = 1;
      tick();
      tick();
   endtask

   task automatic t_reset();
      do_reset();
      ceq("R1 state", state_code, 0);
      ceq("R1 enables", {inrush_en, conv_en, pg}, 0);
      ceq("R1 retry_cnt", retry_cnt, 0);
      ceq("R1 action/lockout", {action, lockout}, 0);
      ceq("R1 first_code", first_code, 0);
   endtask

   task automatic t_startup();
      do_reset();
      det_done = 1;
      tick();
      ceq("R2 inrush state", state_code, 1);
      ceq("R2 inrush enables", {inrush_en, conv_en}, 2'b10);
      ceq("R13 evt on entry", evt, 1);
      tick();
      ceq("R13 evt steady", evt, 0);
      bulk_ok = 1;
      tick();
      ceq("R2 run state", state_code, 2);
      ceq("R2 run enables", {inrush_en, conv_en}, 2'b01);
      repeat (PG_QUAL - 1) tick();
      ceq("R12 pg before qual", pg, 0);
      tick();
      ceq("R12 pg after qual", pg, 1);
      ocp = 1; fault_cls = 2'd1;
      tick();
      ocp = 0;
      ceq("R12 fault state", state_code, 3);
      ceq("R12 pg falls with fault", pg, 0);
      ceq("R6 first_code", first_code, 3);
      ceq("R6 first_state", first_state, 2);
      ceq("R6 action not yet applied", action, 0);
      tick();
      ceq("R8 hiccup action", action, 2);
   endtask

   task automatic t_hiccup();
      int n;
      do_reset();
      fault_cls = 2'd1;
      go_run();
      for (int i = 0; i < 2; i++) begin
         if (i == 0) ocp = 1; else otp = 1;
         tick();
         ocp = 0; otp = 0;
         tick();
         dwell(3'd4, n);
         ceq("R8 hiccup dwell", n, BASE);
         tick();
      end
      ceq("R6 first fault kept", first_code, 3);
      ceq("R11 retry count", retry_cnt, 2);
   endtask

   task automatic t_backoff();
      int n;
      int exp_d[3] = '{4, 8, 8};
      do_reset();
      det_done = 1; bulk_ok = 0; fault_cls = 2'd0;
      tick();
      for (int i = 0; i < 3; i++) begin
         dwell(3'd1, n);
         if (i == 0) begin
            ceq("R3 inrush timeout length", n, INRUSH_TO);
            ceq("R3 timeout code", first_code, 6);
            ceq("R6 first_state inrush", first_state, 1);
         end
         tick();
         ceq("R11 retry count", retry_cnt, i + 1);
         ceq("R9 backoff action", action, 3);
         dwell(3'd4, n);
         ceq("R9 backoff dwell", n, exp_d[i]);
      end
      dwell(3'd1, n);
      tick();
      ceq("R11 lockout", lockout, 1);
      ceq("R11 lockout action", action, 1);
      repeat (30) tick();
      ceq("R11 held in fault", state_code, 3);
      det_done = 0; clear_latch = 1;
      tick();
      clear_latch = 0;
      ceq("R7 clear to idle", state_code, 0);
      ceq("R7 clear lockout", lockout, 0);
      ceq("R7 clear count", retry_cnt, 0);
      ceq("R7 clear first_code", first_code, 0);
   endtask

   task automatic t_stable();
      int n;
      do_reset();
      det_done = 1; bulk_ok = 0; fault_cls = 2'd0;
      tick();
      dwell(3'd1, n);
      tick();
      bulk_ok = 1;
      dwell(3'd4, n);
      ceq("R9 first delay base", n, BASE);
      tick();
      repeat (10) tick();
      ocp = 1; tick(); ocp = 0; tick();
      dwell(3'd4, n);
      ceq("R9 delay doubled after short run", n, 2 * BASE);
      tick();
      repeat (40) tick();
      ocp = 1; tick(); ocp = 0; tick();
      dwell(3'd4, n);
      ceq("R10 delay restored after stable run", n, BASE);
   endtask

   task automatic t_window();
      do_reset();
      fault_cls = 2'd0;
      go_run();
      ocp = 1; tick(); ocp = 0; tick();
      ceq("R11 count after retry", retry_cnt, 1);
      repeat (100) tick();
      ceq("R11 count inside window", retry_cnt, 1);
      repeat (350) tick();
      ceq("R11 count after window", retry_cnt, 0);
   endtask

   task automatic t_uvlo();
      do_reset();
      uvlo_trip = 1; tick(); uvlo_trip = 0; uvlo_clear = 0;
      det_done = 1;
      repeat (10) tick();
      ceq("R4 idle held without release", state_code, 0);
      uvlo_clear = 1;
      tick();
      tick();
      ceq("R4 inrush after release", state_code, 1);
      bulk_ok = 1;
      tick();
      uvlo_clear = 0;
      repeat (20) tick();
      ceq("R4 run kept without release flag", state_code, 2);
      uvlo_trip = 1; tick(); uvlo_trip = 0;
      ceq("R4 trip enters fault", state_code, 3);
      ceq("R5 uvlo code", first_code, 1);
      repeat (20) tick();
      ceq("R4 retry held until release", state_code, 4);
      uvlo_clear = 1;
      tick();
      ceq("R4 still retry one edge after release", state_code, 4);
      tick();
      ceq("R4 inrush two edges after release", state_code, 1);
   endtask

   task automatic t_latch();
      do_reset();
      go_run();
      clear_latch = 1; tick(); clear_latch = 0;
      ceq("R7 clear ignored in run", state_code, 2);
      ceq("R7 clear ignored record", first_code, 0);
      ovp = 1; short_det = 1; fault_cls = 2'd2;
      tick();
      ovp = 0; short_det = 0;
      ceq("R5 short beats ovp", first_code, 5);
      tick();
      ceq("R7 latch action", action, 1);
      ceq("R7 latch is not lockout", lockout, 0);
      repeat (20) tick();
      ceq("R7 latched in fault", state_code, 3);
      det_done = 0; clear_latch = 1; tick(); clear_latch = 0;
      ceq("R7 cleared to idle", state_code, 0);
      ceq("R7 action cleared", action, 0);
      go_run();
      ocp = 1; ovp = 1; tick(); ocp = 0; ovp = 0;
      ceq("R5 ocp beats ovp", first_code, 3);
      otp = 1; ocp = 1; det_done = 0;
      tick(); tick();
      otp = 0; ocp = 0; clear_latch = 1; tick(); clear_latch = 0;
      go_run();
      otp = 1; ocp = 1; tick(); otp = 0; ocp = 0;
      ceq("R5 otp beats ocp", first_code, 4);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_startup();
      t_hiccup();
      t_backoff();
      t_stable();
      t_window();
      t_uvlo();
      t_latch();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule